// File: doc/BRIEF.md
# Pulse-and-verify EPROM programming controller

This block writes a byte image into a byte-wide, electrically programmable read-only memory. Each target byte is programmed with a short, fixed-length strobe pulse, and every pulse is followed by a read-back. The controller moves to the next location only when the byte read back equals the target. If a location still does not match after a fixed number of pulses, the controller gives up and the whole run is marked as failed. Cells that are erased read as all ones, so a target of all ones needs no pulse and the location is passed over at once.

A run begins with a one-cycle `start` pulse, which also captures an inclusive address range. The controller then switches on the logic supply enable, and after that the programming supply enable. Target bytes arrive one per address, in ascending address order, over a valid/ready stream. The device pins the controller drives are the address, the write data together with its bus-drive enable, an active-low chip select, an active-low read enable and an active-low program strobe. Every timing window is a cycle-count parameter. At the end of a run the controller drops the programming supply first and the logic supply after it. It raises `done` for one cycle and holds the result on `status` until the next run starts.

Top module: `eprom_prog_ctrl`

## Requirements
- R1: `vcc_en` rises in the cycle after `start` is accepted. `vpp_en` rises SETUP_CYC cycles later. `vpp_en` is never high while `vcc_en` is low. At the end, `vpp_en` falls SETUP_CYC cycles before `vcc_en` falls.
- R2: While `dev_pgm_n` is low, `dev_ce_n` is low, `dev_oe_n` is high and the data bus is driven (`dev_wdata_oe`=1). `dev_ce_n` also stays low through every read-back.
- R3: When `dev_pgm_n` falls, address and data have been unchanged for at least SETUP_CYC cycles, with `dev_ce_n` low, `dev_oe_n` high and the bus driven all that time. `vpp_en` has also been high for at least SETUP_CYC cycles.
- R4: Each program pulse holds `dev_pgm_n` low for exactly PULSE_CYC cycles.
- R5: After `dev_pgm_n` rises, the data bus stays driven with unchanged data for at least SETUP_CYC cycles.
- R6: A read-back holds `dev_oe_n` low for exactly VALID_CYC cycles with the bus released. `dev_rdata` is sampled at the clock edge that ends that window.
- R7: When the read-back equals the target, the address is reported with `addr_done`=1 and `addr_ok`=1 and the controller moves on. A mismatch with fewer than MAX_PULSES pulses applied leads to another pulse.
- R8: A mismatch after MAX_PULSES pulses reports the address with `addr_ok`=0. It latches that address on `fail_addr`, stops taking bytes and shuts the supplies down. Later addresses get no pulse.
- R9: A target byte of all ones causes no pulse and is reported as passed.
- R10: `status` encodes 0 = idle since reset, 1 = busy, 2 = finished ok, 3 = finished with failure. A result is held until the next `start`.
- R11: `done` is high for exactly one cycle per run. That is the last cycle with `vcc_en` high, and `vpp_en` is already low.
- R12: `pulse_cnt` gives the number of pulses applied to the address being worked on, or to the last address handled. It never exceeds MAX_PULSES.
- R13: A byte is taken on a clock edge where `src_valid` and `src_ready` are both high. `src_ready` is high only while no strobe or bus drive is active. Exactly one byte is taken per handled address, in address order from the first address to the last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (used only while idle) |
| first_addr | input | AW | First address of the range |
| last_addr | input | AW | Last address of the range (inclusive) |
| src_valid | input | 1 | Target byte available |
| src_data | input | DW | Target byte |
| src_ready | output | 1 | Controller waits for a target byte |
| dev_addr | output | AW | Device address |
| dev_wdata | output | DW | Data presented to the device |
| dev_wdata_oe | output | 1 | Drive the device data bus |
| dev_rdata | input | DW | Data read from the device |
| dev_ce_n | output | 1 | Active-low chip select |
| dev_oe_n | output | 1 | Active-low read enable |
| dev_pgm_n | output | 1 | Active-low program strobe |
| vcc_en | output | 1 | Logic supply enable |
| vpp_en | output | 1 | Programming supply enable |
| addr_done | output | 1 | One-cycle per-address result strobe |
| addr_ok | output | 1 | Result of the reported address |
| status | output | 2 | Run status code |
| fail_addr | output | AW | Address that failed |
| pulse_cnt | output | PCW | Pulses used at the current or last address |
| done | output | 1 | One-cycle end-of-run strobe |

## Verification
The bench includes a device model that needs a chosen number of pulses per cell before the cell takes the written value. Its read data are wrong until the read enable has been low for the valid delay. One run mixes cells that need one, two, three and the maximum number of pulses with blank bytes, and feeds the bytes with stalls. This shows that the controller stops pulsing at the first match and samples neither too early nor too late. A cell that needs one pulse more than the limit shows that the controller stops at the limit and leaves later addresses alone. A cell whose already-cleared bits can never return to one fails after a match that never comes. An all-blank range separates the skip path from the pulse path. A protocol monitor on every clock measures setup, pulse width, hold and supply ordering.

// File: rtl/prog_pkg.sv
package prog_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_VCC_UP,
    S_VPP_UP,
    S_FETCH,
    S_SETUP,
    S_PULSE,
    S_HOLD,
    S_VERIFY,
    S_NEXT,
    S_DOWN
  } pstate_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_OK   = 2'd2,
    ST_FAIL = 2'd3
  } stat_e;

endpackage

// File: rtl/prog_timer.sv
module prog_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_nx;

  always_comb begin
    if (load)               cnt_nx = load_val;
    else if (cnt_q != '0)   cnt_nx = cnt_q - 1'b1;
    else                    cnt_nx = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end

  assign expired = (cnt_q == '0);

  AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R4

endmodule

// File: rtl/prog_pulse_ctr.sv
module prog_pulse_ctr #(
  parameter int MAX_PULSES = 20,
  parameter int PCW        = $clog2(MAX_PULSES + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           inc,
  output logic [PCW-1:0] count,
  output logic           at_limit
);

  logic [PCW-1:0] cnt_q;
  logic [PCW-1:0] cnt_nx;

  always_comb begin
    if (clr)      cnt_nx = '0;
    else if (inc) cnt_nx = cnt_q + 1'b1;
    else          cnt_nx = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end

  assign count    = cnt_q;
  assign at_limit = (cnt_q == PCW'(MAX_PULSES));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> !at_limit); // R8

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= PCW'(MAX_PULSES)); // R12

endmodule

// File: rtl/eprom_prog_ctrl.sv
module eprom_prog_ctrl
  import prog_pkg::*;
#(
  parameter int AW         = 13,
  parameter int DW         = 8,
  parameter int SETUP_CYC  = 100,
  parameter int PULSE_CYC  = 25000,
  parameter int VALID_CYC  = 8,
  parameter int MAX_PULSES = 20,
  parameter int PCW        = $clog2(MAX_PULSES + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [AW-1:0]  first_addr,
  input  logic [AW-1:0]  last_addr,
  input  logic           src_valid,
  input  logic [DW-1:0]  src_data,
  output logic           src_ready,
  output logic [AW-1:0]  dev_addr,
  output logic [DW-1:0]  dev_wdata,
  output logic           dev_wdata_oe,
  input  logic [DW-1:0]  dev_rdata,
  output logic           dev_ce_n,
  output logic           dev_oe_n,
  output logic           dev_pgm_n,
  output logic           vcc_en,
  output logic           vpp_en,
  output logic           addr_done,
  output logic           addr_ok,
  output logic [1:0]     status,
  output logic [AW-1:0]  fail_addr,
  output logic [PCW-1:0] pulse_cnt,
  output logic           done
);

  localparam int MAX_SV = (SETUP_CYC > VALID_CYC) ? SETUP_CYC : VALID_CYC;
  localparam int MAXC   = (PULSE_CYC > MAX_SV) ? PULSE_CYC : MAX_SV;
  localparam int TW     = $clog2(MAXC) + 1;

  pstate_e        state_q, state_nx;
  logic [AW-1:0]  addr_q, last_q, fail_addr_q;
  logic [DW-1:0]  data_q;
  logic           ok_q, fail_q;
  stat_e          res_q;

  logic           tmr_load, tmr_exp;
  logic [TW-1:0]  tmr_val;
  logic [PCW-1:0] pcnt;
  logic           at_limit, pc_clr, pc_inc;
  logic           byte_acc, blank, match;

  assign byte_acc = (state_q == S_FETCH) && src_valid;
  assign blank    = (src_data == '1);
  assign match    = (dev_rdata == data_q);

  // next-state logic
  always_comb begin
    state_nx = state_q;
    unique case (state_q)
      S_IDLE:   if (start)   state_nx = S_VCC_UP;
      S_VCC_UP: if (tmr_exp) state_nx = S_VPP_UP;
      S_VPP_UP: if (tmr_exp) state_nx = S_FETCH;
      S_FETCH:  if (src_valid) state_nx = blank ? S_NEXT : S_SETUP;
      S_SETUP:  if (tmr_exp) state_nx = S_PULSE;
      S_PULSE:  if (tmr_exp) state_nx = S_HOLD;
      S_HOLD:   if (tmr_exp) state_nx = S_VERIFY;
      S_VERIFY: if (tmr_exp) state_nx = (match || at_limit) ? S_NEXT : S_SETUP;
      S_NEXT:   state_nx = (!ok_q || addr_q == last_q) ? S_DOWN : S_FETCH;
      S_DOWN:   if (tmr_exp) state_nx = S_IDLE;
      default:  state_nx = S_IDLE;
    endcase
  end

  // phase length loaded on each state change
  assign tmr_load = (state_nx != state_q);

  always_comb begin
    unique case (state_nx)
      S_VCC_UP, S_VPP_UP, S_SETUP, S_HOLD, S_DOWN: tmr_val = TW'(SETUP_CYC - 1);
      S_PULSE:  tmr_val = TW'(PULSE_CYC - 1);
      S_VERIFY: tmr_val = TW'(VALID_CYC - 1);
      default:  tmr_val = '0;
    endcase
  end

  prog_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  assign pc_clr = (state_q == S_FETCH);
  assign pc_inc = (state_q == S_SETUP) && tmr_exp;

  prog_pulse_ctr #(.MAX_PULSES(MAX_PULSES), .PCW(PCW)) u_pulses (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (pc_clr),
    .inc      (pc_inc),
    .count    (pcnt),
    .at_limit (at_limit)
  );

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      addr_q      <= '0;
      last_q      <= '0;
      fail_addr_q <= '0;
      data_q      <= '0;
      ok_q        <= 1'b0;
      fail_q      <= 1'b0;
      res_q       <= ST_IDLE;
    end else begin
      state_q <= state_nx;
      if (state_q == S_IDLE && start) begin
        addr_q      <= first_addr;
        last_q      <= last_addr;
        fail_q      <= 1'b0;
        fail_addr_q <= '0;
      end else if (state_q == S_NEXT && state_nx == S_FETCH) begin
        addr_q <= addr_q + 1'b1;
      end
      if (byte_acc) data_q <= src_data;
      if (byte_acc && blank)                  ok_q <= 1'b1;
      else if (state_q == S_VERIFY && tmr_exp) ok_q <= match;
      if (state_q == S_NEXT && !ok_q) begin
        fail_q      <= 1'b1;
        fail_addr_q <= addr_q;
      end
      if (state_q == S_DOWN && tmr_exp) res_q <= fail_q ? ST_FAIL : ST_OK;
    end
  end

  // outputs
  assign src_ready    = (state_q == S_FETCH);
  assign dev_addr     = addr_q;
  assign dev_wdata    = data_q;
  assign dev_wdata_oe = state_q inside {S_SETUP, S_PULSE, S_HOLD};
  assign dev_ce_n     = !(state_q inside {S_FETCH, S_SETUP, S_PULSE, S_HOLD, S_VERIFY, S_NEXT});
  assign dev_oe_n     = (state_q != S_VERIFY);
  assign dev_pgm_n    = (state_q != S_PULSE);
  assign vcc_en       = (state_q != S_IDLE);
  assign vpp_en       = !(state_q inside {S_IDLE, S_VCC_UP, S_DOWN});
  assign addr_done    = (state_q == S_NEXT);
  assign addr_ok      = ok_q;
  assign status       = (state_q == S_IDLE) ? res_q : ST_BUSY;
  assign fail_addr    = fail_addr_q;
  assign pulse_cnt    = pcnt;
  assign done         = (state_q == S_DOWN) && tmr_exp;

  AST_VPP_WITH_VCC: assert property (@(posedge clk) disable iff (!rst_n)
    vpp_en |-> vcc_en); // R1

  AST_STROBE_GATING: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_pgm_n |-> (!dev_ce_n && dev_oe_n && dev_wdata_oe && vpp_en)); // R2

  AST_PULSE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_pgm_n && !tmr_exp) |=> (!dev_pgm_n && $stable(dev_wdata) && $stable(dev_addr))); // R4

  AST_BUS_FREE_VERIFY: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_oe_n |-> (!dev_wdata_oe && !dev_ce_n)); // R6

  AST_SKIP_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && src_ready && src_data == '1) |=> (addr_done && addr_ok && dev_pgm_n)); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !vcc_en)); // R11

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> (dev_pgm_n && !dev_wdata_oe)); // R13

endmodule

// File: tb/test_eprom_prog_ctrl.sv
module test_eprom_prog_ctrl;

  localparam int AW  = 8;
  localparam int DW  = 8;
  localparam int SU  = 4;
  localparam int PW  = 10;
  localparam int VC  = 3;
  localparam int MP  = 4;
  localparam int PCW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic           start = 1'b0;
  logic [AW-1:0]  first_addr = '0, last_addr = '0;
  logic           src_valid = 1'b0;
  logic [DW-1:0]  src_data = '0;
  logic           src_ready;
  logic [AW-1:0]  dev_addr;
  logic [DW-1:0]  dev_wdata, dev_rdata;
  logic           dev_wdata_oe, dev_ce_n, dev_oe_n, dev_pgm_n;
  logic           vcc_en, vpp_en, addr_done, addr_ok, done;
  logic [1:0]     status;
  logic [AW-1:0]  fail_addr;
  logic [PCW-1:0] pulse_cnt;

  eprom_prog_ctrl #(
    .AW(AW), .DW(DW), .SETUP_CYC(SU), .PULSE_CYC(PW), .VALID_CYC(VC),
    .MAX_PULSES(MP), .PCW(PCW)
  ) i_eprom_prog_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .first_addr(first_addr),
    .last_addr(last_addr), .src_valid(src_valid), .src_data(src_data),
    .src_ready(src_ready), .dev_addr(dev_addr), .dev_wdata(dev_wdata),
    .dev_wdata_oe(dev_wdata_oe), .dev_rdata(dev_rdata), .dev_ce_n(dev_ce_n),
    .dev_oe_n(dev_oe_n), .dev_pgm_n(dev_pgm_n), .vcc_en(vcc_en),
    .vpp_en(vpp_en), .addr_done(addr_done), .addr_ok(addr_ok),
    .status(status), .fail_addr(fail_addr), .pulse_cnt(pulse_cnt), .done(done)
  );

  // device model: cell takes the written value after need[] pulses
  logic [7:0] mem [256];
  logic [7:0] pre [256];
  logic [7:0] tgt [256];
  int         need[256];
  int         pc  [256];
  int         oe_lo = 0;

  always @(posedge clk) oe_lo <= dev_oe_n ? 0 : oe_lo + 1;
  assign dev_rdata = (oe_lo >= VC - 1) ? mem[dev_addr] : ~mem[dev_addr];

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_ok(int a);
    if (tgt[a] == 8'hFF) return 1'b1;
    return (need[a] <= MP) && ((pre[a] & tgt[a]) == tgt[a]);
  endfunction

  function automatic int exp_pc(int a);
    if (tgt[a] == 8'hFF) return 0;
    if (exp_ok(a)) return need[a];
    return MP;
  endfunction

  // cycle-by-cycle protocol reference
  bit   p_vcc = 0, p_vpp = 0, p_pgm = 1, p_oe = 1, in_hold = 0;
  int   vcc_hi = 0, vpp_hi = 0, vpp_lo = 0, su = 0, pl = 0, ol = 0, hd = 0;
  logic [AW-1:0] pa = '0;
  logic [DW-1:0] pd = '0, hdata = '0;
  int   exp_next = 0, nbytes = 0, ndone = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      chk(!vpp_en || vcc_en, "R1", "vpp without vcc", vpp_en, vcc_en);
      if (vpp_en && !p_vpp) chk(vcc_hi >= SU, "R1", "vcc lead cycles", vcc_hi, SU);
      if (!vcc_en && p_vcc) chk(vpp_lo >= SU, "R1", "vpp-off lead cycles", vpp_lo, SU);

      if (!dev_pgm_n) begin
        chk(!dev_ce_n && dev_oe_n && dev_wdata_oe, "R2", "pins during pulse",
            {dev_ce_n, dev_oe_n, dev_wdata_oe}, 3'b011);
        if (p_pgm) begin
          chk(su >= SU, "R3", "setup cycles", su, SU);
          chk(vpp_hi >= SU, "R3", "vpp before pulse", vpp_hi, SU);
          pl = 0;
        end
        pl++;
      end
      if (dev_pgm_n && !p_pgm) begin
        chk(pl == PW, "R4", "pulse width", pl, PW);
        pc[dev_addr]++;
        if (pc[dev_addr] >= need[dev_addr]) mem[dev_addr] = mem[dev_addr] & dev_wdata;
        in_hold = 1;
        hd = 0;
        hdata = dev_wdata;
      end
      if (in_hold) begin
        if (dev_wdata_oe && dev_pgm_n && dev_wdata == hdata) hd++;
        else begin
          chk(hd >= SU, "R5", "hold cycles", hd, SU);
          in_hold = 0;
        end
      end
      if (!dev_ce_n && dev_oe_n && dev_wdata_oe && dev_pgm_n)
        su = (su > 0 && dev_addr == pa && dev_wdata == pd) ? su + 1 : 1;
      else if (dev_pgm_n) su = 0;

      if (!dev_oe_n) begin
        chk(!dev_wdata_oe && !dev_ce_n, "R6", "bus during read-back",
            {dev_wdata_oe, dev_ce_n}, 2'b00);
        ol++;
      end else begin
        if (!p_oe) chk(ol == VC, "R6", "read-back length", ol, VC);
        ol = 0;
      end

      if (src_ready) chk(dev_pgm_n && dev_oe_n && !dev_wdata_oe, "R13", "ready while busy",
                         {dev_pgm_n, dev_oe_n, dev_wdata_oe}, 3'b110);
      if (src_ready && src_valid) nbytes++;

      if (addr_done) begin
        chk(dev_addr == exp_next[AW-1:0], "R13", "address order", dev_addr, exp_next);
        chk(addr_ok == exp_ok(exp_next), exp_ok(exp_next) ? "R7" : "R8", "addr_ok",
            addr_ok, exp_ok(exp_next));
        chk(pulse_cnt == exp_pc(exp_next), "R12", "pulse_cnt at report", pulse_cnt,
            exp_pc(exp_next));
        chk(pc[exp_next] == exp_pc(exp_next), (tgt[exp_next] == 8'hFF) ? "R9" : "R7",
            "pulses applied", pc[exp_next], exp_pc(exp_next));
        exp_next++;
      end

      if (done) begin
        ndone++;
        chk(vcc_en && !vpp_en, "R11", "supplies at done", {vcc_en, vpp_en}, 2'b10);
      end

      vcc_hi = vcc_en ? vcc_hi + 1 : 0;
      vpp_hi = vpp_en ? vpp_hi + 1 : 0;
      vpp_lo = vpp_en ? 0 : vpp_lo + 1;
      p_vcc = vcc_en; p_vpp = vpp_en; p_pgm = dev_pgm_n; p_oe = dev_oe_n;
      pa = dev_addr; pd = dev_wdata;
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic run_case(input int first, input int last, input int stall);
    int n_exp, fail_a, last_h;
    n_exp = 0; fail_a = -1;
    for (int a = first; a <= last; a++) begin
      mem[a] = pre[a];
      pc[a]  = 0;
    end
    for (int a = first; a <= last; a++) begin
      n_exp++;
      if (!exp_ok(a)) begin fail_a = a; break; end
    end
    last_h = first + n_exp - 1;
    exp_next = first; nbytes = 0; ndone = 0;

    @(negedge clk);
    start = 1'b1; first_addr = first[AW-1:0]; last_addr = last[AW-1:0];
    @(negedge clk);
    start = 1'b0;
    chk(vcc_en && !vpp_en, "R1", "vcc first", {vcc_en, vpp_en}, 2'b10);
    @(negedge clk);
    chk(status == 2'd1, "R10", "busy code", status, 1);

    for (int i = 0; i < n_exp; i++) begin
      repeat (stall) @(negedge clk);
      src_valid = 1'b1;
      src_data  = tgt[first + i];
      while (!src_ready) @(negedge clk);
      @(negedge clk);
      src_valid = 1'b0;
    end
    while (ndone == 0) @(negedge clk);
    @(negedge clk);

    chk(!vcc_en && !done, "R11", "after done", {vcc_en, done}, 2'b00);
    chk(ndone == 1, "R11", "done count", ndone, 1);
    chk(nbytes == n_exp, "R13", "bytes taken", nbytes, n_exp);
    chk(exp_next == first + n_exp, "R7", "addresses reported", exp_next, first + n_exp);
    chk(status == ((fail_a < 0) ? 2'd2 : 2'd3), "R10", "result code", status,
        (fail_a < 0) ? 2 : 3);
    if (fail_a >= 0) chk(fail_addr == fail_a[AW-1:0], "R8", "fail_addr", fail_addr, fail_a);
    chk(pulse_cnt == exp_pc(last_h), "R12", "pulse_cnt at end", pulse_cnt, exp_pc(last_h));
    for (int a = first; a <= last; a++) begin
      if (a <= last_h) begin
        logic [7:0] e;
        e = (tgt[a] != 8'hFF && exp_pc(a) >= need[a]) ? (pre[a] & tgt[a]) : pre[a];
        chk(mem[a] == e, "R7", "cell content", mem[a], e);
      end else begin
        chk(pc[a] == 0, "R8", "pulses after failure", pc[a], 0);
      end
    end
  endtask

  initial begin
    for (int a = 0; a < 256; a++) begin
      mem[a] = 8'hFF; pre[a] = 8'hFF; tgt[a] = 8'hFF; need[a] = 1; pc[a] = 0;
    end
    repeat (3) @(negedge clk);
    chk(status == 2'd0, "R10", "reset status", status, 0);
    chk(!vcc_en && !vpp_en, "R1", "reset supplies", {vcc_en, vpp_en}, 0);
    chk(dev_ce_n && dev_oe_n && dev_pgm_n, "R2", "reset strobes",
        {dev_ce_n, dev_oe_n, dev_pgm_n}, 3'b111);
    chk(!done && !src_ready, "R11", "reset done/ready", {done, src_ready}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // mixed pulse counts with blank bytes, stalled source
    tgt[16] = 8'h3C; need[16] = 1;
    tgt[17] = 8'hFF;
    tgt[18] = 8'h00; need[18] = MP;
    tgt[19] = 8'hA5; need[19] = 2;
    tgt[20] = 8'hFF;
    tgt[21] = 8'h81; need[21] = 3;
    run_case(16, 21, 2);

    // cell needing one pulse beyond the limit
    tgt[32] = 8'h12; need[32] = 2;
    tgt[33] = 8'h34; need[33] = 1;
    tgt[34] = 8'h56; need[34] = MP + 1;
    tgt[35] = 8'h78; need[35] = 1;
    tgt[36] = 8'h9A; need[36] = 1;
    run_case(32, 36, 0);
    repeat (5) @(negedge clk);
    chk(status == 2'd3, "R10", "result held", status, 3);

    // cleared bits cannot return to one
    pre[64] = 8'h0F; tgt[64] = 8'hF0; need[64] = 1;
    run_case(64, 64, 1);

    // all blank range
    run_case(80, 82, 0);

    finish_run();
  end

endmodule